// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing protocol engine of a 1 KiB serial EEPROM. It oversamples the two-wire clock (SCL) and data (SDA) lines with a faster system clock. From them it recognises START, repeated START and STOP conditions and shifts bytes in and out. It answers a 7-bit device address whose fixed prefix is `1010`. The next bit must match a strap pin, and the two bits after that select one of four 256-byte banks. It drives SDA as an open-drain output: `sda_oe` high means the pin is pulled low.

Write transactions carry a word address and then up to `PAGE` data bytes, which are gathered in a page buffer. On STOP the buffer is copied into the array one byte per clock. A programming timer then keeps the device busy, and while it is busy the device refuses its address. Reads come in three kinds: from the current pointer, random (set the pointer by a write, issue a repeated START, then read), and sequential over any number of bytes. The byte pointer advances only within the selected bank. A write-protect input locks the upper two banks.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device address byte is `1010`, then a bit that must equal `sel_pin`, then bank bits [2:1] (array address bits 9:8), then R/W in bit 0 (1 = read). On a mismatch the slave does not acknowledge and keeps SDA released until the next START or STOP.
- R2: In a write, the slave acknowledges the device address, the word address and every accepted data byte. Up to `PAGE` data bytes are stored at consecutive pointer values, starting at the word address, once STOP arrives.
- R3: The 8-bit byte pointer increments after every accepted data byte, in both directions. The bank never changes, so the pointer wraps from 255 to 0 inside the same bank.
- R4: A random read (a word address write, a repeated START, then the address with R/W = 1) returns data from the word address just given.
- R5: A read that starts directly with R/W = 1 returns data from the pointer left by the previous access.
- R6: A sequential read streams successive bytes while the master acknowledges. After the master's NACK the slave releases SDA.
- R7: While `wp` is high and bank bit 2 of the address is 1 (upper 512 bytes), the device and word address are acknowledged, but data bytes are not, and nothing is written or made busy.
- R8: For `WR_CYCLES` clocks after the copy that follows STOP, the slave does not acknowledge its device address. Afterwards it does again.
- R9: A data byte beyond `PAGE` in one write is not acknowledged, and the whole write is discarded at STOP.
- R10: The slave changes SDA only while SCL is low. A START in the middle of a byte aborts the transaction without writing anything.
- R11: After reset SDA is released, the pointer is 0 and the bank is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_pin | input | 1 | Strap compared with device address bit 3 |
| wp | input | 1 | Write protect for banks 2 and 3 |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |

## Verification
The bench targets pointer wrap at 255 inside bank 1. A design that carried the increment into the bank bits would return bytes from bank 2. It probes the address phase right after a STOP: a missing busy lockout shows up as an ACK. It also sends a ninth page byte and then reads back the page. A design that programmed the partial page, or acknowledged the extra byte, would be visible there. The bench also aborts a write halfway through a byte with a repeated START and writes under protection. A design that committed on any STOP, or that acknowledged protected data, would change the bytes read back.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int PAGE      = 8,
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sel_pin,
  input  logic wp,
  output logic sda_oe
);
  localparam int CW    = $clog2(PAGE + 1);
  localparam int PW    = (PAGE > 1) ? $clog2(PAGE) : 1;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int DEPTH = 1024;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_READ, S_IGN} st_t;

  logic [1:0] scl_p, sda_p;
  logic       scl_s, sda_s, scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr, wbase, rdata;
  logic [1:0] bank;
  logic       rnw, mack, ovf, commit;
  logic [CW-1:0] wcount, cnum, ci;
  logic [TW-1:0] timer;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 2'b11; sda_p <= 2'b11; scl_s <= 1'b1; sda_s <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[0], scl_i}; sda_p <= {sda_p[0], sda_i};
      scl_s <= scl_p[1]; sda_s <= sda_p[1];
      scl_q <= scl_s; sda_q <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire busy     = commit | (timer != '0);
  wire dev_ok   = (sh[7:4] == 4'b1010) && (sh[3] == sel_pin) && !busy;
  wire locked   = wp & bank[1];
  wire ack_slot = scl_fall && !start_c && !stop_c && (bitcnt == 4'd8);
  wire wr_take  = ack_slot && (st == S_WDAT) && !locked && !ovf && (wcount != CW'(PAGE));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= 8'hFF; ptr <= '0; wbase <= '0;
      bank <= '0; rnw <= 1'b0; mack <= 1'b0; ovf <= 1'b0; sda_oe <= 1'b0;
      wcount <= '0; cnum <= '0; ci <= '0; commit <= 1'b0; timer <= '0;
    end else begin
      if (start_c) begin
        st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0; wcount <= '0; ovf <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
        if (st == S_WDAT && wcount != '0 && !ovf && !busy) begin
          commit <= 1'b1; cnum <= wcount; ci <= '0;
        end
      end else if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (st != S_READ) sh <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (st == S_READ) begin
            mack <= ~sda_s;
            ptr  <= ptr + 8'd1;
          end
        end
      end else if (scl_fall) begin
        if (st == S_READ && bitcnt != 4'd0 && bitcnt < 4'd8) begin
          sh <= {sh[6:0], 1'b1};
          sda_oe <= ~sh[6];
        end else if (bitcnt == 4'd8) begin
          case (st)
            S_DEV: if (dev_ok) begin
              sda_oe <= 1'b1; bank <= sh[2:1]; rnw <= sh[0];
            end
            S_WADR: begin sda_oe <= 1'b1; ptr <= sh; wbase <= sh; end
            S_WDAT:
              if (wr_take) begin
                sda_oe <= 1'b1; wcount <= wcount + 1'b1; ptr <= ptr + 8'd1;
              end else if (!locked) ovf <= 1'b1;
            S_READ: sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            S_DEV:
              if (!sda_oe) st <= S_IGN;
              else if (rnw) begin
                st <= S_READ; sh <= rdata; sda_oe <= ~rdata[7];
              end else st <= S_WADR;
            S_WADR: st <= S_WDAT;
            S_READ:
              if (mack) begin sh <= rdata; sda_oe <= ~rdata[7]; end
              else st <= S_IGN;
            default: ;
          endcase
        end
      end

      if (commit) begin
        ci <= ci + 1'b1;
        if (ci == cnum - 1'b1) begin
          commit <= 1'b0;
          timer  <= TW'(WR_CYCLES);
        end
      end else if (timer != '0) timer <= timer - 1'b1;
    end

  always_ff @(posedge clk) begin
    if (wr_take) pbuf[wcount[PW-1:0]] <= sh;
    if (commit) mem[{bank, wbase + 8'(ci)}] <= pbuf[ci[PW-1:0]];
    rdata <= mem[{bank, ptr}];
  end

  // R10
  sda_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && st == S_DEV && busy) |=> !sda_oe);
  // R7
  wp_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && st == S_WDAT && wp && bank[1]) |=> !sda_oe);
  // R9
  ovf_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && st == S_WDAT && wcount == CW'(PAGE)) |=> !sda_oe);
  // R1
  ign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 10;
  localparam int PAGE  = 8;
  localparam int WRC   = 2000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_eeprom_slave #(.PAGE(PAGE), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel_pin(1'b0), .wp(wp), .sda_oe(sda_oe));

  task automatic wq(); #(Q*CLK_P); endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1; wq(); wq(); scl = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; wq(); scl = 1; wq(); ack = ~sda_line; wq(); scl = 0; wq();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1; wq(); d[i] = sda_line; wq(); scl = 0;
    end
    sda_m = ~mack; wq(); scl = 1; wq(); wq(); scl = 0; wq(); sda_m = 1;
  endtask

  function automatic logic [7:0] dev(input logic [1:0] bk, input logic rd);
    return {4'b1010, 1'b0, bk, rd};
  endfunction

  task automatic do_write(input logic [1:0] bk, input logic [7:0] a, input int n,
                          input logic [7:0] v0, input bit dat_ok, input string tag);
    logic ack;
    bus_start();
    put_byte(dev(bk, 0), ack); chk({tag, " dev ack"}, ack, 1);
    put_byte(a, ack);          chk({tag, " word addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(v0 + 8'(i), ack);
      chk({tag, " data ack"}, ack, (dat_ok && i < PAGE) ? 1 : 0);
    end
    bus_stop();
  endtask

  task automatic read_seq(input int n, input logic [7:0] e0, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      chk({tag, " read data"}, d, e0 + 8'(i));
    end
    chk({tag, " R6 released after master NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  task automatic do_rd(input logic [1:0] bk, input logic [7:0] a, input int n,
                       input logic [7:0] e0, input string tag);
    logic ack;
    bus_start();
    put_byte(dev(bk, 0), ack); chk({tag, " R4 dev ack"}, ack, 1);
    put_byte(a, ack);          chk({tag, " R4 addr ack"}, ack, 1);
    bus_start();
    put_byte(dev(bk, 1), ack); chk({tag, " R4 read dev ack"}, ack, 1);
    read_seq(n, e0, tag);
  endtask

  task automatic settle(); repeat (WRC + 100) @(posedge clk); #3; endtask

  task automatic t_reset();
    chk("R11 sda released at reset", sda_oe, 0);
  endtask

  task automatic t_write_read();
    logic ack;
    do_write(2'd0, 8'h10, 4, 8'h40, 1, "R2");
    bus_start(); put_byte(dev(0, 0), ack); bus_stop();
    chk("R8 busy nack", ack, 0);
    settle();
    do_rd(2'd0, 8'h10, 3, 8'h40, "R4 random");
    bus_start(); put_byte(dev(0, 1), ack); chk("R5 current dev ack", ack, 1);
    read_seq(1, 8'h43, "R5 current");
  endtask

  task automatic t_wrap();
    do_write(2'd1, 8'hFE, 3, 8'h21, 1, "R3 wr");
    settle();
    do_rd(2'd1, 8'hFF, 2, 8'h22, "R3 wrap");
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start(); put_byte(8'hA8, ack); chk("R1 strap mismatch nack", ack, 0);
    put_byte(8'h00, ack); chk("R1 stays released", ack, 0); bus_stop();
    bus_start(); put_byte(8'hB0, ack); chk("R1 prefix mismatch nack", ack, 0); bus_stop();
  endtask

  task automatic t_wp();
    logic ack;
    do_write(2'd2, 8'h30, 2, 8'h90, 1, "R7 pre");
    settle();
    wp = 1;
    do_write(2'd2, 8'h30, 1, 8'h77, 0, "R7 locked");
    bus_start(); put_byte(dev(2, 0), ack); bus_stop();
    chk("R7 not busy after locked write", ack, 1);
    do_rd(2'd2, 8'h30, 2, 8'h90, "R7 unchanged");
    do_write(2'd0, 8'h80, 1, 8'h5A, 1, "R7 lower bank");
    settle();
    wp = 0;
    do_rd(2'd0, 8'h80, 1, 8'h5A, "R7 lower written");
  endtask

  task automatic t_page();
    logic ack;
    do_write(2'd3, 8'h40, PAGE, 8'hC0, 1, "R9 fill");
    settle();
    do_write(2'd3, 8'h40, PAGE + 1, 8'h00, 1, "R9 overflow");
    bus_start(); put_byte(dev(3, 0), ack); bus_stop();
    chk("R9 discarded, not busy", ack, 1);
    do_rd(2'd3, 8'h40, 2, 8'hC0, "R9 old data");
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    put_byte(dev(0, 0), ack); chk("R10 dev ack", ack, 1);
    put_byte(8'h12, ack);     chk("R10 addr ack", ack, 1);
    put_bit(1); put_bit(0); put_bit(1);
    bus_start();
    put_byte(dev(0, 1), ack); chk("R10 read after abort ack", ack, 1);
    read_seq(1, 8'h42, "R10 abort");
  endtask

  initial begin
    #3;
    #(5*CLK_P) rst_n = 1;
    wq();
    t_reset();
    t_write_read();
    t_wrap();
    t_mismatch();
    t_wp();
    t_page();
    t_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule